// File: doc/BRIEF.md
# Cold Reset Sequencer with Boot-Vector Capture

This block orders the bring-up of a chip after a power-on (cold) reset. While the active-low cold-reset input is held low, it keeps the system reset active and pulls the shared reset pin low. It also holds the external bus transceiver in its reset setting, keeps the data bus and the other outputs undriven, and gates off the external clock. On every clock edge during this time it loads the 16-bit data bus into a boot-vector register. The last value loaded before cold reset is released stays in that register afterwards for software to read.

On release, the cold-reset input is first passed through a two-flop synchronizer. The block then takes back the bus in three steps, one cycle apart. First it drives the data bus. Next it disables the transceiver and turns its direction outward. Last it enables the external clock and the remaining outputs. A hold counter then keeps reset asserted for a parameterised number of cycles (at least 4096). After that the system reset is released, the reset pin stops being driven, and the pin is watched as an active-low warm-reset request.

A warm request re-asserts the system reset for as long as the pin stays low, and it does not touch the boot vector. A new cold reset at any point restarts the whole sequence. A PCI reset output stays undriven until the host-mode enable is set and the cold phase is over. From then on it follows the system reset.

Top module: `cold_reset_seq`

## Requirements
- R1: When `cold_rst_n` goes low, then in the same cycle and without waiting for a clock edge, `sys_rst_n` is 0, `rst_pin_oe` is 1 (the reset pin is driven low) and `buf_oe_n` is 0.
- R2: While the sequencer is in its cold phase, `buf_dir`, `ext_clk_en`, `bus_oe` and `pins_oe` are all 0.
- R3: On every rising clock edge at which `cold_rst_n` is low, `boot_vec` loads `bus_in`. On edges with `cold_rst_n` high, `boot_vec` keeps its value, so after release it holds the bus value from the last edge before release.
- R4: After `cold_rst_n` rises, the outputs keep their cold values through the first two rising edges (synchronizer). `bus_oe` becomes 1 after the third edge. `buf_oe_n` and `buf_dir` become 1 after the fourth edge. `ext_clk_en` and `pins_oe` become 1 after the fifth edge. All of this happens well inside 16 cycles.
- R5: The hold count starts at the sixth edge after release. `sys_rst_n` stays 0 through edge 5+HOLD_CYCLES and becomes 1 after edge 6+HOLD_CYCLES (HOLD_CYCLES ≥ 4096).
- R6: Whenever `sys_rst_n` is 1 following the sequence, `rst_pin_oe` is 0.
- R7: Once the sequence is complete, a high-to-low change on `rst_pin_in` sets `sys_rst_n` to 0 after the third rising edge following the change. The reset stays at 0 while the pin is low and is released after the third edge following the pin's return high. `boot_vec` does not change during this.
- R8: `pci_rst_oe` is 1 only when `pci_host_en` is 1 and the sequencer is past its cold phase. `pci_rst_o` always equals `sys_rst_n`.
- R9: A cold-reset assertion during the bus handover or the hold count returns the block at once to the cold phase. The next release then repeats the full timing of R4 and R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| cold_rst_n | input | 1 | Active-low cold-reset input, asynchronous |
| bus_in | input | 16 | Data bus as seen at the pads, sampled as the boot vector |
| rst_pin_in | input | 1 | Reset pin as seen at its pad, a warm-reset request when low |
| pci_host_en | input | 1 | PCI interface enabled in host mode |
| sys_rst_n | output | 1 | Active-low system reset to the rest of the chip |
| rst_pin_oe | output | 1 | Drive the reset pin low when 1 |
| buf_oe_n | output | 1 | Active-low output enable of the bus transceiver |
| buf_dir | output | 1 | Transceiver direction, 1 outward |
| bus_oe | output | 1 | Drive enable for the data bus |
| pins_oe | output | 1 | Drive enable for the remaining outputs |
| ext_clk_en | output | 1 | External clock output enable |
| boot_vec | output | 16 | Captured boot configuration vector |
| pci_rst_oe | output | 1 | Drive enable of the PCI reset output |
| pci_rst_o | output | 1 | Value on the PCI reset output |

## Verification
The effect of cold-reset assertion is combinational, so the bench checks it two time units after it changes the input, before the next clock edge. The boot-vector register takes one edge to follow the bus. Each handover step is due a known number of edges after release: three, four and five. The reset release falls exactly at edge 6+HOLD_CYCLES, and a warm request takes three edges in each direction. The driver counts falling edges from the stimulus and queues the expected output word for exactly that falling edge. The monitor compares shortly after it, so every comparison sits half a period away from the edge that updates the outputs.

// File: rtl/crs_pkg.sv
package crs_pkg;

  typedef enum logic [2:0] {
    ST_COLD  = 3'd0,
    ST_BUS   = 3'd1,
    ST_XCVR  = 3'd2,
    ST_CLKON = 3'd3,
    ST_HOLD  = 3'd4,
    ST_RUN   = 3'd5,
    ST_WARM  = 3'd6
  } crs_state_e;

  typedef struct packed {
    logic sys_rst_n;
    logic pin_oe;
    logic buf_oe_n;
    logic buf_dir;
    logic bus_oe;
    logic pins_oe;
    logic clk_en;
  } crs_ctl_t;

  // counter width able to hold values 0..n-1
  function automatic int unsigned cnt_width(int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  // output controls for each sequencer state
  function automatic crs_ctl_t decode(crs_state_e s);
    crs_ctl_t c;
    c = '{sys_rst_n: 1'b0, pin_oe: 1'b1, buf_oe_n: 1'b0, buf_dir: 1'b0,
          bus_oe: 1'b0, pins_oe: 1'b0, clk_en: 1'b0};
    case (s)
      ST_BUS:   c.bus_oe = 1'b1;
      ST_XCVR:  begin c.bus_oe = 1'b1; c.buf_oe_n = 1'b1; c.buf_dir = 1'b1; end
      ST_CLKON,
      ST_HOLD:  begin
        c.bus_oe = 1'b1; c.buf_oe_n = 1'b1; c.buf_dir = 1'b1;
        c.pins_oe = 1'b1; c.clk_en = 1'b1;
      end
      ST_RUN,
      ST_WARM:  begin
        c.bus_oe = 1'b1; c.buf_oe_n = 1'b1; c.buf_dir = 1'b1;
        c.pins_oe = 1'b1; c.clk_en = 1'b1; c.pin_oe = 1'b0;
        c.sys_rst_n = (s == ST_RUN);
      end
      default: ;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/crs_sync.sv
module crs_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              d,
  output logic [STAGES-1:0] q
);
  // stage 0 samples d; each later stage takes the one before it
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) q[0] <= RST_VAL;
    else         q[0] <= d;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) q[g] <= RST_VAL;
      else         q[g] <= q[g-1];
    end
  end
endmodule

// File: rtl/crs_vec_cap.sv
module crs_vec_cap #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         cold_rst_n,
  input  logic [W-1:0] bus_in,
  output logic [W-1:0] vec
);
  // no reset here: the register has to keep loading while cold reset is low
  always_ff @(posedge clk) begin
    if (!cold_rst_n) vec <= bus_in;
  end
endmodule

// File: rtl/crs_seq_fsm.sv
module crs_seq_fsm
  import crs_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES = 4096
) (
  input  logic       clk,
  input  logic       arst_n,
  input  logic       cold_ok,
  input  logic       pin_now,
  input  logic       pin_prev,
  output crs_state_e state,
  output logic       hold_done,
  output logic       warm_fall
);
  localparam int unsigned CW = cnt_width(HOLD_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

  logic [CW-1:0] cnt;
  crs_state_e    nxt;

  assign hold_done = (state == ST_HOLD) && (cnt == LAST);
  assign warm_fall = (state == ST_RUN) && !pin_now && pin_prev;

  always_comb begin
    nxt = state;
    case (state)
      ST_COLD:  if (cold_ok) nxt = ST_BUS;
      ST_BUS:   nxt = ST_XCVR;
      ST_XCVR:  nxt = ST_CLKON;
      ST_CLKON: nxt = ST_HOLD;
      ST_HOLD:  if (hold_done) nxt = ST_RUN;
      ST_RUN:   if (warm_fall) nxt = ST_WARM;
      ST_WARM:  if (pin_now) nxt = ST_RUN;
      default:  nxt = ST_COLD;
    endcase
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state <= ST_COLD;
      cnt   <= '0;
    end else begin
      state <= nxt;
      cnt   <= (state == ST_HOLD && !hold_done) ? cnt + 1'b1 : '0;
    end
  end
endmodule

// File: rtl/cold_reset_seq.sv
module cold_reset_seq
  import crs_pkg::*;
#(
  parameter int unsigned VEC_W       = 16,
  parameter int unsigned HOLD_CYCLES = 4096
) (
  input  logic             clk,
  input  logic             cold_rst_n,
  input  logic [VEC_W-1:0] bus_in,
  input  logic             rst_pin_in,
  input  logic             pci_host_en,
  output logic             sys_rst_n,
  output logic             rst_pin_oe,
  output logic             buf_oe_n,
  output logic             buf_dir,
  output logic             bus_oe,
  output logic             pins_oe,
  output logic             ext_clk_en,
  output logic [VEC_W-1:0] boot_vec,
  output logic             pci_rst_oe,
  output logic             pci_rst_o
);
  logic [1:0] cold_q;
  logic [2:0] pin_q;
  logic       cold_ok;
  logic       hold_done;
  logic       warm_fall;
  crs_state_e state;
  crs_ctl_t   ctl;

  crs_sync #(.STAGES(2), .RST_VAL(1'b0)) u_cold_sync (
    .clk(clk), .arst_n(cold_rst_n), .d(1'b1), .q(cold_q)
  );

  crs_sync #(.STAGES(3), .RST_VAL(1'b1)) u_pin_sync (
    .clk(clk), .arst_n(cold_rst_n), .d(rst_pin_in), .q(pin_q)
  );

  assign cold_ok = cold_q[1];

  crs_vec_cap #(.W(VEC_W)) u_vec (
    .clk(clk), .cold_rst_n(cold_rst_n), .bus_in(bus_in), .vec(boot_vec)
  );

  crs_seq_fsm #(.HOLD_CYCLES(HOLD_CYCLES)) u_fsm (
    .clk(clk), .arst_n(cold_rst_n), .cold_ok(cold_ok),
    .pin_now(pin_q[1]), .pin_prev(pin_q[2]),
    .state(state), .hold_done(hold_done), .warm_fall(warm_fall)
  );

  assign ctl        = decode(state);
  assign sys_rst_n  = ctl.sys_rst_n;
  assign rst_pin_oe = ctl.pin_oe;
  assign buf_oe_n   = ctl.buf_oe_n;
  assign buf_dir    = ctl.buf_dir;
  assign bus_oe     = ctl.bus_oe;
  assign pins_oe    = ctl.pins_oe;
  assign ext_clk_en = ctl.clk_en;
  assign pci_rst_oe = pci_host_en && (state != ST_COLD);
  assign pci_rst_o  = ctl.sys_rst_n;
endmodule

// File: rtl/crs_checker.sv
module crs_checker #(
  parameter int unsigned VEC_W       = 16,
  parameter int unsigned HOLD_CYCLES = 4096
) (
  input logic             clk,
  input logic             cold_rst_n,
  input logic [VEC_W-1:0] boot_vec,
  input logic             pci_host_en,
  input logic             sys_rst_n,
  input logic             rst_pin_oe,
  input logic             buf_oe_n,
  input logic             buf_dir,
  input logic             bus_oe,
  input logic             pins_oe,
  input logic             ext_clk_en,
  input logic             pci_rst_oe,
  input logic             pci_rst_o
);
  localparam int unsigned RW = $clog2(HOLD_CYCLES + 2) + 1;

  logic [1:0]    age = '0;
  logic [RW-1:0] pre_run = '0;
  logic          armed;

  always_ff @(posedge clk) if (age != 2'd3) age <= age + 2'd1;
  assign armed = (age >= 2'd2);

  // cycles spent with the clock enabled while reset is still being driven
  always_ff @(posedge clk) begin
    if (!cold_rst_n)                   pre_run <= '0;
    else if (rst_pin_oe && ext_clk_en) pre_run <= (pre_run == '1) ? pre_run : pre_run + 1'b1;
    else                               pre_run <= '0;
  end

  a_r1_cold_asserts: assert property (@(posedge clk) disable iff (!armed)
    !cold_rst_n |-> (!sys_rst_n && rst_pin_oe && !buf_oe_n));

  a_r2_cold_quiet: assert property (@(posedge clk) disable iff (!armed)
    !cold_rst_n |-> (!buf_dir && !ext_clk_en && !bus_oe && !pins_oe));

  a_r3_vec_frozen: assert property (@(posedge clk) disable iff (!armed)
    $past(cold_rst_n) |-> $stable(boot_vec));

  a_r4_clk_after_bus: assert property (@(posedge clk) disable iff (!armed)
    $rose(ext_clk_en) |-> (bus_oe && buf_oe_n && buf_dir && $past(bus_oe)));

  a_r4_bus_first: assert property (@(posedge clk) disable iff (!armed)
    $rose(bus_oe) |-> (!ext_clk_en && !buf_dir));

  a_r5_hold_length: assert property (@(posedge clk) disable iff (!armed)
    $fell(rst_pin_oe) |-> (pre_run >= RW'(HOLD_CYCLES)));

  a_r6_pin_released: assert property (@(posedge clk) disable iff (!armed)
    sys_rst_n |-> !rst_pin_oe);

  a_r8_pci_gate: assert property (@(posedge clk) disable iff (!armed)
    pci_rst_oe |-> (pci_host_en && cold_rst_n));

  a_r8_pci_follow: assert property (@(posedge clk) disable iff (!armed)
    pci_rst_o == sys_rst_n);
endmodule

bind cold_reset_seq crs_checker #(.VEC_W(VEC_W), .HOLD_CYCLES(HOLD_CYCLES)) u_crs_checker (
  .clk(clk), .cold_rst_n(cold_rst_n), .boot_vec(boot_vec), .pci_host_en(pci_host_en),
  .sys_rst_n(sys_rst_n), .rst_pin_oe(rst_pin_oe), .buf_oe_n(buf_oe_n), .buf_dir(buf_dir),
  .bus_oe(bus_oe), .pins_oe(pins_oe), .ext_clk_en(ext_clk_en),
  .pci_rst_oe(pci_rst_oe), .pci_rst_o(pci_rst_o)
);

// File: tb/test_cold_reset_seq.sv
`timescale 1ns/1ps
module test_cold_reset_seq;
  localparam int HOLD = 4096;

  logic        clk = 1'b0;
  logic        cold_rst_n;
  logic [15:0] bus_in;
  logic        rst_pin_in;
  logic        pci_host_en;
  logic        sys_rst_n, rst_pin_oe, buf_oe_n, buf_dir, bus_oe, pins_oe, ext_clk_en;
  logic [15:0] boot_vec;
  logic        pci_rst_oe, pci_rst_o;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  typedef struct {
    string       req;
    logic [24:0] exp;
    logic [24:0] mask;
  } sb_item_t;
  sb_item_t sb_q[$];

  always #2.5 clk = ~clk;

  cold_reset_seq #(.VEC_W(16), .HOLD_CYCLES(HOLD)) i_cold_reset_seq (
    .clk(clk), .cold_rst_n(cold_rst_n), .bus_in(bus_in), .rst_pin_in(rst_pin_in),
    .pci_host_en(pci_host_en), .sys_rst_n(sys_rst_n), .rst_pin_oe(rst_pin_oe),
    .buf_oe_n(buf_oe_n), .buf_dir(buf_dir), .bus_oe(bus_oe), .pins_oe(pins_oe),
    .ext_clk_en(ext_clk_en), .boot_vec(boot_vec), .pci_rst_oe(pci_rst_oe),
    .pci_rst_o(pci_rst_o)
  );

  // phases: 0 cold, 1 bus, 2 xcvr, 3 clock on, 4 hold, 5 run, 6 warm
  // word: {sys_rst_n, rst_pin_oe, buf_oe_n, buf_dir, bus_oe, pins_oe, ext_clk_en, pci_oe, pci_o}
  function automatic logic [8:0] model(int ph, logic host);
    logic rst, pin, boe, dir, bo, po, ce, poe;
    rst = (ph == 5);
    pin = (ph < 5);
    bo  = (ph >= 1);
    boe = (ph >= 2);
    dir = (ph >= 2);
    po  = (ph >= 3);
    ce  = (ph >= 3);
    poe = host && (ph != 0);
    return {rst, pin, boe, dir, bo, po, ce, poe, rst};
  endfunction

  function automatic logic [24:0] observed();
    return {boot_vec, sys_rst_n, rst_pin_oe, buf_oe_n, buf_dir, bus_oe, pins_oe,
            ext_clk_en, pci_rst_oe, pci_rst_o};
  endfunction

  // driver side: queue the expectation for the current falling edge
  task automatic expect_now(string req, int ph, logic [15:0] vec, bit vec_known);
    sb_item_t it;
    it.req  = req;
    it.exp  = {vec, model(ph, pci_host_en)};
    it.mask = {vec_known ? 16'hFFFF : 16'h0000, 9'h1FF};
    sb_q.push_back(it);
  endtask

  // monitor side: compare shortly after each falling edge
  always @(negedge clk) begin
    #2;
    while (sb_q.size() > 0) begin
      sb_item_t it;
      it = sb_q.pop_front();
      compared++;
      if ((observed() & it.mask) !== (it.exp & it.mask)) begin
        mismatched++;
        $display("FAIL %s at %0t: actual %h expected %h (mask %h)",
                 it.req, $time, observed(), it.exp, it.mask);
      end
    end
  end

  // release cold reset and follow the sequence up to edge stop_k
  task automatic release_run(logic [15:0] vec, string tag, int stop_k);
    @(negedge clk);
    cold_rst_n = 1'b1;
    bus_in = 16'h0000;
    for (int k = 1; k <= stop_k; k++) begin
      @(negedge clk);
      if (k <= 2)            expect_now({tag, " R4 sync"}, 0, vec, 1);
      else if (k == 3)       expect_now({tag, " R4 bus"}, 1, vec, 1);
      else if (k == 4)       expect_now({tag, " R4 xcvr"}, 2, vec, 1);
      else if (k == 5)       expect_now({tag, " R4 clk"}, 3, vec, 1);
      else if (k == 6)       expect_now({tag, " R5 hold start"}, 4, vec, 1);
      else if (k == 5+HOLD)  expect_now({tag, " R5 last hold"}, 4, vec, 1);
      else if (k == 6+HOLD)  expect_now({tag, " R5 R6 release"}, 5, vec, 1);
    end
  endtask

  initial begin
    cold_rst_n = 1'b0;
    bus_in = 16'hA5C3;
    rst_pin_in = 1'b1;
    pci_host_en = 1'b0;

    @(negedge clk);
    expect_now("R1 R2 reset state", 0, 16'hA5C3, 1);
    bus_in = 16'h1111;
    @(negedge clk);
    expect_now("R3 sample", 0, 16'h1111, 1);
    bus_in = 16'hBEEF;
    @(negedge clk);
    expect_now("R3 last sample", 0, 16'hBEEF, 1);

    release_run(16'hBEEF, "first", 6 + HOLD);

    // PCI host mode after the sequence
    @(negedge clk);
    pci_host_en = 1'b1;
    expect_now("R8 host drive", 5, 16'hBEEF, 1);

    // warm request
    @(negedge clk);
    rst_pin_in = 1'b0;
    bus_in = 16'h7777;
    @(negedge clk); expect_now("R7 no early warm", 5, 16'hBEEF, 1);
    @(negedge clk); expect_now("R7 no early warm", 5, 16'hBEEF, 1);
    @(negedge clk); expect_now("R7 warm asserted", 6, 16'hBEEF, 1);
    repeat (4) @(negedge clk);
    expect_now("R7 warm held", 6, 16'hBEEF, 1);
    rst_pin_in = 1'b1;
    @(negedge clk); expect_now("R7 warm held", 6, 16'hBEEF, 1);
    @(negedge clk); expect_now("R7 warm held", 6, 16'hBEEF, 1);
    @(negedge clk); expect_now("R7 warm released", 5, 16'hBEEF, 1);

    // fresh cold reset with PCI host mode on
    @(negedge clk);
    cold_rst_n = 1'b0;
    bus_in = 16'h5A5A;
    expect_now("R1 R8 async cold", 0, 16'hBEEF, 1);
    @(negedge clk);
    expect_now("R3 R8 resample", 0, 16'h5A5A, 1);

    release_run(16'h5A5A, "abort", 7);
    cold_rst_n = 1'b0;
    bus_in = 16'hC33C;
    expect_now("R9 R1 abort to cold", 0, 16'h5A5A, 1);
    repeat (3) @(negedge clk);
    expect_now("R9 R2 cold again", 0, 16'hC33C, 1);

    release_run(16'hC33C, "R9 restart", 6 + HOLD);

    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule